// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column-access request into the run of column addresses that a READ or WRITE burst walks through on an SDRAM row of 512 columns. A request carries a start column, a three-bit length code and an ordering bit. It is qualified by a one-cycle start strobe. From the next clock on, the block presents one column address per cycle with a valid flag. It marks the final beat with a last flag.

For the fixed lengths of 1, 2, 4 and 8, every address stays inside the aligned group of columns that holds the start column. The group is as wide as the burst. Only the offset bits inside the group move. They either count upward with wrap-around or are the start offset XORed with the beat number. The page length instead walks upward through the whole row, wrapping from 511 to 0. It ends only when the terminate input is asserted. A controller uses the valid and last flags to pace its column commands, and it can request the next burst on the last beat so that bursts run back to back.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While rst_ni is low, and until the first accepted start, valid_o and last_o are 0 and col_o is 0.
- R2: A start accepted at a clock edge makes valid_o 1 and col_o equal to start_col_i after that same edge. Length code and ordering bit are captured at that edge, and later changes on these inputs have no effect on the running burst.
- R3: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. last_o is 1 on the final beat only, and valid_o falls the cycle after it unless a new start is accepted.
- R4: With ilv_i = 0 (sequential), beat k carries offset (start offset + k) mod L, where L is the burst length and the start offset is the low log2(L) bits of the start column.
- R5: With ilv_i = 1 (interleaved), beat k carries offset (start offset XOR k).
- R6: For fixed lengths, the column bits above the low log2(L) bits equal those of the start column on every beat.
- R7: Length code 3'b111 selects a page burst. It counts up by one per beat from the start column and wraps from 511 to 0. It never raises last_o and ignores ilv_i.
- R8: term_i sampled high during an active burst ends it, and valid_o is 0 the following cycle.
- R9: The reserved length codes 3'b100, 3'b101 and 3'b110 behave as length 1.
- R10: A start strobe during an active burst whose current beat is not the last is ignored, and the burst continues unchanged.
- R11: A start strobe on the last beat is accepted, and the first beat of the new burst follows with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst request strobe |
| start_col_i | input | 9 | Start column of the burst |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| term_i | input | 1 | Ends the active burst |
| col_o | output | 9 | Current column address |
| valid_o | output | 1 | col_o carries a burst beat |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench builds the block with its default column width of 9 bits. This makes the real row boundary reachable. A page burst started a few columns below 511 crosses the wrap to 0 in a handful of cycles. Eight-beat groups near the top of the row show that the upper bits hold while the low three bits wrap. Back-to-back and ignored starts are driven against bursts of different lengths, so that the captured configuration is seen to stay with its own burst.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  typedef enum logic [2:0] {
    BL_ONE   = 3'b000,
    BL_TWO   = 3'b001,
    BL_FOUR  = 3'b010,
    BL_EIGHT = 3'b011,
    BL_PAGE  = 3'b111
  } blen_e;
endpackage

// File: rtl/colgen_cfg_dec.sv
module colgen_cfg_dec
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o,
  output logic             ilv_o
);
  always_comb begin
    page_o = 1'b0;
    unique case (len_code_i)
      BL_TWO:   mask_o = COL_W'(1);
      BL_FOUR:  mask_o = COL_W'(3);
      BL_EIGHT: mask_o = COL_W'(7);
      BL_PAGE: begin
        mask_o = '1;
        page_o = 1'b1;
      end
      default:  mask_o = '0; // length 1, including reserved codes
    endcase
    ilv_o = ilv_i & ~page_o;
  end
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr #(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  input  logic [COL_W-1:0] beat_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_w, ilv_w;

  assign seq_w = base_i + beat_i;
  assign ilv_w = base_i ^ beat_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? (ilv_i ? ilv_w[b] : seq_w[b]) : base_i[b];
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] dec_mask, mask_q, base_q, beat_q, beat_nxt, col_q, addr_nxt;
  logic             dec_page, dec_ilv, page_q, ilv_q, busy_q, last_q, accept;

  colgen_cfg_dec #(.COL_W(COL_W)) i_dec (
    .len_code_i(len_code_i),
    .ilv_i     (ilv_i),
    .mask_o    (dec_mask),
    .page_o    (dec_page),
    .ilv_o     (dec_ilv)
  );

  assign beat_nxt = beat_q + COL_W'(1);

  colgen_addr #(.COL_W(COL_W)) i_addr (
    .base_i(base_q),
    .mask_i(mask_q),
    .ilv_i (ilv_q),
    .beat_i(beat_nxt),
    .col_o (addr_nxt)
  );

  // new request only when idle or on the closing beat
  assign accept = start_i && (!busy_q || last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mask_q <= '0;
      page_q <= 1'b0;
      ilv_q  <= 1'b0;
      beat_q <= '0;
      col_q  <= '0;
      busy_q <= 1'b0;
      last_q <= 1'b0;
    end else if (accept) begin
      base_q <= start_col_i;
      mask_q <= dec_mask;
      page_q <= dec_page;
      ilv_q  <= dec_ilv;
      beat_q <= '0;
      col_q  <= start_col_i;
      busy_q <= 1'b1;
      last_q <= !dec_page && (dec_mask == '0);
    end else if (busy_q) begin
      if (last_q || term_i) begin
        busy_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        beat_q <= beat_nxt;
        col_q  <= addr_nxt;
        last_q <= !page_q && (beat_nxt == mask_q);
      end
    end
  end

  assign col_o   = col_q;
  assign valid_o = busy_q;
  assign last_o  = last_q;

  assert_last_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && last_o && !start_i) |=> !valid_o);

  assert_block_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && !$past(last_o) && !$past(term_i))
      |-> ((col_o & ~mask_q) == ($past(col_o) & ~mask_q)));

  assert_seq_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ilv_q && $past(valid_o) && !$past(last_o) && !$past(term_i))
      |-> (((col_o - $past(col_o)) & mask_q) == COL_W'(1)));

  assert_page_no_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && page_q) |-> !last_o);

  assert_term_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && term_i && !last_o) |=> !valid_o);

  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !term_i && start_i) |=> (valid_o && beat_q == $past(beat_q) + COL_W'(1)));
endmodule

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       term_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o, last_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  sdram_burst_colgen i_sdram_burst_colgen (.*);

  always #4 clk_i = ~clk_i;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_col(int base, int len, bit ilv, int k);
    int off = base % len;
    int blk = base - off;
    if (ilv) return blk + (off ^ k);
    return blk + ((off + k) % len);
  endfunction

  task automatic launch(int base, logic [2:0] code, bit ilv);
    @(negedge clk_i);
    start_i = 1'b1; start_col_i = 9'(base); len_code_i = code; ilv_i = ilv;
    @(negedge clk_i);
    start_i = 1'b0; len_code_i = 3'b011; ilv_i = ~ilv; start_col_i = 9'h1ff;
  endtask

  task automatic run_fixed(string req, int base, logic [2:0] code, bit ilv, int len);
    launch(base, code, ilv);
    for (int k = 0; k < len; k++) begin
      chk(req, "valid", int'(valid_o), 1);
      chk(req, "col", int'(col_o), exp_col(base, len, ilv, k));
      chk(req, "last", int'(last_o), int'(k == len - 1));
      @(negedge clk_i);
    end
    chk(req, "valid after last", int'(valid_o), 0);
  endtask

  task automatic t_page_term();
    launch(508, 3'b111, 1'b1);
    for (int k = 0; k < 6; k++) begin
      chk("R7", "page valid", int'(valid_o), 1);
      chk("R7", "page col", int'(col_o), (508 + k) % 512);
      chk("R7", "page last", int'(last_o), 0);
      if (k == 5) term_i = 1'b1;
      @(negedge clk_i);
    end
    term_i = 1'b0;
    chk("R8", "valid after term", int'(valid_o), 0);
  endtask

  task automatic t_term_fixed();
    launch(16, 3'b011, 1'b0);
    chk("R8", "col beat0", int'(col_o), 16);
    term_i = 1'b1;
    @(negedge clk_i);
    term_i = 1'b0;
    chk("R8", "valid after early term", int'(valid_o), 0);
  endtask

  task automatic t_ignore_start();
    launch(5, 3'b010, 1'b0);
    chk("R10", "beat0", int'(col_o), 5);
    @(negedge clk_i);
    chk("R10", "beat1", int'(col_o), 6);
    start_i = 1'b1; start_col_i = 9'd100; len_code_i = 3'b000;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R10", "beat2", int'(col_o), 7);
    chk("R10", "valid", int'(valid_o), 1);
    @(negedge clk_i);
    chk("R10", "beat3", int'(col_o), 4);
    chk("R10", "last", int'(last_o), 1);
    @(negedge clk_i);
    chk("R10", "valid after", int'(valid_o), 0);
  endtask

  task automatic t_back_to_back();
    launch(10, 3'b001, 1'b0);
    chk("R11", "beat0", int'(col_o), 10);
    @(negedge clk_i);
    chk("R11", "beat1", int'(col_o), 11);
    chk("R11", "last", int'(last_o), 1);
    start_i = 1'b1; start_col_i = 9'd33; len_code_i = 3'b010; ilv_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; len_code_i = 3'b000; ilv_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R11", "next valid", int'(valid_o), 1);
      chk("R11", "next col", int'(col_o), exp_col(33, 4, 1'b1, k));
      chk("R11", "next last", int'(last_o), int'(k == 3));
      @(negedge clk_i);
    end
    chk("R11", "valid after", int'(valid_o), 0);
  endtask

  initial begin
    #3;
    chk("R1", "valid in reset", int'(valid_o), 0);
    chk("R1", "last in reset", int'(last_o), 0);
    chk("R1", "col in reset", int'(col_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "valid after reset", int'(valid_o), 0);
    run_fixed("R2", 77, 3'b000, 1'b0, 1);
    run_fixed("R3", 9, 3'b001, 1'b0, 2);
    run_fixed("R4", 13, 3'b010, 1'b0, 4);
    run_fixed("R6", 510, 3'b011, 1'b0, 8);
    run_fixed("R5", 5, 3'b011, 1'b1, 8);
    run_fixed("R5", 258, 3'b010, 1'b1, 4);
    run_fixed("R9", 40, 3'b101, 1'b0, 1);
    run_fixed("R9", 41, 3'b100, 1'b1, 1);
    run_fixed("R9", 42, 3'b110, 1'b0, 1);
    t_page_term();
    t_term_fixed();
    t_ignore_start();
    t_back_to_back();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule